// File: doc/BRIEF.md
# Atomic Swap Memory Unit

This block is a small single-port memory built from an internal register array. Besides plain loads and stores of 1, 2, 4 or 8 bytes, it performs an unconditional exchange and a compare-and-swap as one indivisible read-modify-write. It also accepts an invalidate command that leaves storage alone. Each request carries a command, a byte address, a size code, store data, a compare operand, an inhibit flag and a flag that asks for a response to an invalidate.

The unit takes one request at a time. The memory action happens in the cycle the request is accepted. The response, which carries right-justified read data and an error flag, is presented after a latency. That latency is a fixed base plus a pseudo-random extra of zero up to a configured variation, and it is held until the requester takes it. Requests that are misaligned, fall partly outside the array, use an unknown command, or ask for a compare-and-swap on a 1- or 2-byte size get an error response and change nothing.

Top module: `swapmem_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and every byte of the array reads as zero.
- R2: A load (req_cmd 0) returns the size-selected bytes zero-extended in rsp_rdata. A store (req_cmd 1) writes only those bytes and returns data 0. Size codes 0,1,2,3 mean 1,2,4,8 bytes. Byte address A lives in bits 8*(A mod 8) of word A/8, and the store data is taken from the low bytes of req_wdata.
- R3: An exchange (req_cmd 2) returns the old value at the address and always writes the new data there.
- R4: A compare-and-swap (req_cmd 3) whose old value equals req_cmp, masked to the size, returns the old value and writes the new data.
- R5: A compare-and-swap whose old value differs from the masked req_cmp returns the old value and leaves memory unchanged.
- R6: A compare-and-swap with size code 0 or 1 gives an error response (rsp_err 1) and leaves memory unchanged.
- R7: A request whose address is not a multiple of its size, whose last byte lies past the array, or whose command code is 5 to 7 gives rsp_err 1 with rsp_rdata 0 and leaves memory unchanged.
- R8: A request accepted with req_inhibit 1 produces no response, changes no memory and leaves req_ready high.
- R9: An invalidate (req_cmd 4) changes no memory. It gives a response with rsp_err 0 and data 0 only when req_want_rsp is 1.
- R10: rsp_valid first rises between LAT_BASE and LAT_BASE+LAT_VAR cycles after the acceptance cycle. req_ready stays low from acceptance until the response handshake completes.
- R11: While rsp_valid is high and rsp_ready is low, the response and its data and error stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_cmd | input | 3 | Command code |
| req_size | input | 2 | Size code (1, 2, 4, 8 bytes) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store or swap data, right-justified |
| req_cmp | input | 64 | Compare operand for compare-and-swap |
| req_inhibit | input | 1 | Drop the request entirely |
| req_want_rsp | input | 1 | Invalidate asks for a response |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 64 | Old or loaded value, right-justified |
| rsp_err | output | 1 | Request was rejected |

## Verification
Memory effects happen at the acceptance edge, so every read-back issued later reflects them. Response data is due in a cycle that varies between LAT_BASE and LAT_BASE+LAT_VAR after acceptance. For that reason the bench does not sample at a fixed offset. It drives on falling edges and counts falling-edge samples from acceptance until rsp_valid appears, then checks that count against the window. For requests that must stay silent, it watches rsp_valid for the full window plus margin before checking req_ready.

// File: rtl/swapmem_pkg.sv
package swapmem_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_XCHG  = 3'd2,
        OP_CAS   = 3'd3,
        OP_INVAL = 3'd4
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } unit_state_e;

    typedef struct packed {
        logic        err;
        logic        want;
        logic [63:0] data;
    } rsp_t;

    function automatic logic [3:0] size_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    function automatic logic [7:0] size_lanes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [63:0] size_value_mask(input logic [1:0] sz);
        logic [7:0]  ln;
        logic [63:0] m;
        ln = size_lanes(sz);
        for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{ln[b]}};
        return m;
    endfunction

endpackage

// File: rtl/swapmem_lfsr.sv
module swapmem_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] value
);
    logic [15:0] q;
    logic        fb;

    assign fb    = q[15] ^ q[13] ^ q[12] ^ q[10];
    assign value = q;

    always_ff @(posedge clk) begin
        if (rst) q <= SEED;
        else     q <= {q[14:0], fb};
    end
endmodule

// File: rtl/swapmem_lanes.sv
module swapmem_lanes
    import swapmem_pkg::*;
(
    input  logic [2:0]  off,
    input  logic [1:0]  sz,
    input  logic [63:0] wdata,
    input  logic [63:0] word,
    output logic [7:0]  lanes,
    output logic [63:0] wword,
    output logic [63:0] old_val
);
    logic [5:0] sh;

    assign sh      = {off, 3'b000};
    assign lanes   = size_lanes(sz) << off;
    assign wword   = wdata << sh;
    assign old_val = (word >> sh) & size_value_mask(sz);
endmodule

// File: rtl/swapmem_array.sv
module swapmem_array #(
    parameter int WORDS = 16,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx,
    output logic [63:0]   rd_word,
    input  logic          we,
    input  logic [7:0]    wr_lanes,
    input  logic [63:0]   wr_word
);
    logic [63:0] mem [WORDS];

    assign rd_word = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (we) begin
            for (int b = 0; b < 8; b++)
                if (wr_lanes[b]) mem[idx][b*8 +: 8] <= wr_word[b*8 +: 8];
        end
    end
endmodule

// File: rtl/swapmem_unit.sv
module swapmem_unit
    import swapmem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int WORDS    = 16,
    parameter int LAT_BASE = 2,
    parameter int LAT_VAR  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [63:0]       req_cmp,
    input  logic              req_inhibit,
    input  logic              req_want_rsp,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int IW        = $clog2(WORDS);
    localparam int MEM_BYTES = WORDS * 8;
    localparam int LAT_MAX   = LAT_BASE + LAT_VAR;
    localparam int CW        = $clog2(LAT_MAX + 1);

    unit_state_e   state_q;
    logic [CW-1:0] cnt_q;
    rsp_t          rsp_q;

    op_e           op;
    logic [3:0]    nb;
    logic [31:0]   end_addr;
    logic          is_mem, illegal, misal, oor, badsz, err;
    logic          accept, cas_hit, do_write;
    logic [IW-1:0] word_idx;
    logic [63:0]   rd_word, wr_word, old_val;
    logic [7:0]    wr_lanes;
    logic [15:0]   lfsr_val, extra16;
    logic [CW-1:0] lat_load;
    rsp_t          rsp_next;

    assign op       = op_e'(req_cmd);
    assign nb       = size_bytes(req_size);
    assign end_addr = 32'(req_addr) + 32'(nb);
    assign is_mem   = (req_cmd <= 3'd3);
    assign illegal  = (req_cmd > 3'd4);
    assign misal    = (req_addr[2:0] & (nb[2:0] - 3'd1)) != 3'd0;
    assign oor      = end_addr > 32'(MEM_BYTES);
    assign badsz    = (op == OP_CAS) && (req_size < 2'd2);
    assign err      = illegal | (is_mem & (misal | oor | badsz));
    assign word_idx = req_addr[IW+2:3];

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready && !req_inhibit;
    assign cas_hit   = (old_val == (req_cmp & size_value_mask(req_size)));
    assign do_write  = accept && !err &&
                       ((op == OP_STORE) || (op == OP_XCHG) || ((op == OP_CAS) && cas_hit));

    swapmem_lanes lanes_i (
        .off     (req_addr[2:0]),
        .sz      (req_size),
        .wdata   (req_wdata),
        .word    (rd_word),
        .lanes   (wr_lanes),
        .wword   (wr_word),
        .old_val (old_val)
    );

    swapmem_array #(.WORDS(WORDS)) array_i (
        .clk      (clk),
        .rst      (rst),
        .idx      (word_idx),
        .rd_word  (rd_word),
        .we       (do_write),
        .wr_lanes (wr_lanes),
        .wr_word  (wr_word)
    );

    swapmem_lfsr lfsr_i (
        .clk   (clk),
        .rst   (rst),
        .value (lfsr_val)
    );

    assign extra16  = lfsr_val % 16'(LAT_VAR + 1);
    assign lat_load = CW'(LAT_BASE) + CW'(extra16) - CW'(1);

    always_comb begin
        rsp_next.err  = err;
        rsp_next.want = (op == OP_INVAL) ? req_want_rsp : 1'b1;
        if (!err && ((op == OP_LOAD) || (op == OP_XCHG) || (op == OP_CAS)))
            rsp_next.data = old_val;
        else
            rsp_next.data = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rsp_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= lat_load;
                        rsp_q   <= rsp_next;
                    end
                end
                default: begin
                    if (cnt_q != '0)
                        cnt_q <= cnt_q - CW'(1);
                    else if (!rsp_q.want || rsp_ready)
                        state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign rsp_valid = (state_q == ST_WAIT) && (cnt_q == '0) && rsp_q.want;
    assign rsp_rdata = rsp_q.data;
    assign rsp_err   = rsp_q.err;
endmodule

// File: rtl/swapmem_unit_chk.sv
module swapmem_unit_chk #(
    parameter int LAT_BASE = 2,
    parameter int LAT_VAR  = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_inhibit,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_rdata,
    input logic        rsp_err
);
    logic        pend;
    logic [15:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            wait_cnt <= '0;
        end else if (req_valid && req_ready && !req_inhibit) begin
            pend     <= 1'b1;
            wait_cnt <= 16'd1;
        end else if (pend) begin
            if (rsp_valid || req_ready) pend <= 1'b0;
            if (wait_cnt != 16'hFFFF) wait_cnt <= wait_cnt + 16'd1;
        end
    end

    assert_latency_window_R10: assert property (@(posedge clk) disable iff (rst)
        (pend && rsp_valid) |-> (wait_cnt >= 16'(LAT_BASE) && wait_cnt <= 16'(LAT_BASE + LAT_VAR)));

    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_hold_response_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

    assert_inhibit_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_inhibit) |=> (req_ready && !rsp_valid));

    assert_error_data_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0));
endmodule

bind swapmem_unit swapmem_unit_chk #(.LAT_BASE(LAT_BASE), .LAT_VAR(LAT_VAR)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_inhibit (req_inhibit),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err)
);

// File: tb/swapmem_unit_tb.sv
module swapmem_unit_tb_top;
    localparam int ADDR_W   = 8;
    localparam int WORDS    = 16;
    localparam int LAT_BASE = 2;
    localparam int LAT_VAR  = 3;
    localparam int NBYTES   = WORDS * 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_cmd = '0;
    logic [1:0]        req_size = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic [63:0]       req_cmp = '0;
    logic              req_inhibit = 1'b0;
    logic              req_want_rsp = 1'b0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [63:0]       rsp_rdata;
    logic              rsp_err;

    int  nvec = 0;
    int  nfail = 0;
    int  opn = 0;
    bit  done = 1'b0;
    logic [7:0] ref_mem [NBYTES];

    always #2.5 clk = ~clk;

    swapmem_unit #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LAT_BASE(LAT_BASE), .LAT_VAR(LAT_VAR)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cmp(req_cmp), .req_inhibit(req_inhibit),
        .req_want_rsp(req_want_rsp), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] vmask(input int nb);
        return (nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nb)) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_read(input int a, input int nb);
        logic [63:0] v = '0;
        for (int i = 0; i < nb; i++) v[i*8 +: 8] = ref_mem[a + i];
        return v;
    endfunction

    task automatic ref_write(input int a, input int nb, input logic [63:0] v);
        for (int i = 0; i < nb; i++) ref_mem[a + i] = v[i*8 +: 8];
    endtask

    task automatic op(input int c, input int a, input int s, input logic [63:0] wd,
                      input logic [63:0] cm, input bit inh, input bit want, input string tag);
        int nb, lat, hold, guard;
        bit bad, exp_rsp, got;
        logic [63:0] exp_d, held_d;
        logic held_e;
        nb  = 1 << s;
        bad = (c > 4) || ((c <= 3) && ((a % nb) != 0 || (a + nb) > NBYTES || (c == 3 && s < 2)));
        exp_rsp = !inh && ((c != 4) || want);
        exp_d = 64'd0;
        if (!bad && (c == 0 || c == 2 || c == 3)) exp_d = ref_read(a, nb);
        if (!bad && !inh) begin
            if (c == 1 || c == 2) ref_write(a, nb, wd);
            else if (c == 3 && ref_read(a, nb) == (cm & vmask(nb))) ref_write(a, nb, wd);
        end
        opn++;
        hold = (opn % 5 == 0) ? 2 : 0;

        @(negedge clk);
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_cmd = 3'(c); req_size = 2'(s); req_addr = ADDR_W'(a);
        req_wdata = wd; req_cmp = cm; req_inhibit = inh; req_want_rsp = want;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; got = 1'b0;
        while (lat <= LAT_BASE + LAT_VAR + 3) begin
            if (rsp_valid) begin got = 1'b1; break; end
            @(negedge clk); lat++;
        end
        check(got == exp_rsp, {tag, " response presence"}, 64'(got), 64'(exp_rsp));
        if (got) begin
            check(lat >= LAT_BASE && lat <= LAT_BASE + LAT_VAR, "R10 latency window",
                  64'(lat), 64'(LAT_BASE));
            check(rsp_err == bad, {tag, " error flag"}, 64'(rsp_err), 64'(bad));
            check(rsp_rdata == exp_d, {tag, " data"}, rsp_rdata, exp_d);
            held_d = rsp_rdata; held_e = rsp_err;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check(rsp_valid && rsp_rdata == held_d && rsp_err == held_e,
                      "R11 response held", rsp_rdata, held_d);
                check(!req_ready, "R10 ready low while pending", 64'(req_ready), 64'd0);
            end
            rsp_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rsp_ready = 1'b0;
        end
        check(req_ready, {tag, " R10 ready after completion"}, 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R10 watchdog actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) ref_mem[i] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        for (int w = 0; w < WORDS; w++) op(0, w * 8, 3, 0, 0, 0, 0, "R1 zero word");

        // R2: sweep every size over every aligned address, read back at all sizes
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < NBYTES; a += (1 << s))
                op(1, a, s, 64'h9E37_79B9_7F4A_7C15 * 64'(a + 1 + s * 131), 0, 0, 0, "R2 store");
            for (int s2 = 0; s2 < 4; s2++)
                for (int a = 0; a < NBYTES; a += (1 << s2))
                    op(0, a, s2, 0, 0, 0, 0, "R2 load");
        end

        // R3: exchange
        for (int w = 0; w < WORDS; w++) op(2, w * 8, 3, 64'hA5A5_0000_0000_0000 | 64'(w), 0, 0, 0, "R3 exchange");
        op(2, 12, 2, 64'h1234_5678, 0, 0, 0, "R3 exchange word");
        op(2, 5, 0, 64'hEE, 0, 0, 0, "R3 exchange byte");
        op(0, 8, 3, 0, 0, 0, 0, "R3 readback");

        // R4 / R5: compare-and-swap miss then hit
        for (int w = 0; w < WORDS; w++) begin
            op(3, w * 8, 3, 64'hC0DE_0000_0000_0000 | 64'(w), ref_read(w * 8, 8) ^ 64'd1, 0, 0, "R5 cas miss");
            op(0, w * 8, 3, 0, 0, 0, 0, "R5 unchanged");
            op(3, w * 8, 3, 64'hC0DE_0000_0000_0000 | 64'(w), ref_read(w * 8, 8), 0, 0, "R4 cas hit");
            op(0, w * 8, 3, 0, 0, 0, 0, "R4 written");
        end
        op(3, 20, 2, 64'h7777_7777, 64'hFFFF_FFFF_0000_0000 | ref_read(20, 4), 0, 0, "R4 cas word hit high bits ignored");
        op(3, 24, 2, 64'h6666_6666, ref_read(24, 4) ^ 64'h100, 0, 0, "R5 cas word miss");
        op(0, 16, 3, 0, 0, 0, 0, "R4 readback");
        op(0, 24, 3, 0, 0, 0, 0, "R5 readback");

        // R6: illegal compare-and-swap sizes
        op(3, 0, 0, 64'hFF, ref_read(0, 1), 0, 0, "R6 cas byte");
        op(3, 2, 1, 64'hFFFF, ref_read(2, 2), 0, 0, "R6 cas half");
        op(0, 0, 3, 0, 0, 0, 0, "R6 unchanged");

        // R7: misaligned, out of range, unknown command
        op(1, 1, 1, 64'hDEAD, 0, 0, 0, "R7 misaligned half");
        op(1, 2, 2, 64'hDEAD_BEEF, 0, 0, 0, "R7 misaligned word");
        op(2, 4, 3, 64'h1, 0, 0, 0, "R7 misaligned dword");
        op(0, 3, 3, 0, 0, 0, 0, "R7 misaligned load");
        op(1, 128, 0, 64'h55, 0, 0, 0, "R7 out of range byte");
        op(0, 200, 3, 0, 0, 0, 0, "R7 out of range dword");
        op(5, 8, 3, 64'h9, 0, 0, 0, "R7 unknown command 5");
        op(7, 16, 3, 64'h9, 0, 0, 0, "R7 unknown command 7");
        op(0, 0, 3, 0, 0, 0, 0, "R7 unchanged");

        // R8: inhibit
        op(1, 24, 3, 64'hBAD0_BAD0_BAD0_BAD0, 0, 1, 0, "R8 inhibited store");
        op(2, 32, 3, 64'hBAD1, 0, 1, 0, "R8 inhibited exchange");
        op(0, 24, 3, 0, 0, 0, 0, "R8 unchanged a");
        op(0, 32, 3, 0, 0, 0, 0, "R8 unchanged b");

        // R9: invalidate
        op(4, 40, 3, 64'hFACE, 0, 0, 1, "R9 invalidate with response");
        op(4, 48, 3, 64'hFACE, 0, 0, 0, "R9 invalidate silent");
        op(0, 40, 3, 0, 0, 0, 0, "R9 unchanged a");
        op(0, 48, 3, 0, 0, 0, 0, "R9 unchanged b");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule